// File: doc/BRIEF.md
# Cascadable serial configuration ROM

This block is a one-bit-wide read-only store that streams a fixed bitstream to a downstream device, one bit per clock. A bit address counter selects the bit on the output. The counter moves on by one at each rising clock edge while the chip enable and the output enable are both active. A combined reset/output-enable pin clears the counter and releases the data line, and a parameter sets which level of that pin means reset.

The contents come from a parameter vector or, when that is not used, from a pattern computed inside the block. Once every stored bit has been read, the counter stops one step past the last address and the block stops driving data. It then pulls its cascade enable output low. Several instances can share the clock, the reset/output-enable line and the data line. Each device's cascade enable output drives the next device's chip enable, so the whole chain reads out as one continuous stream. The tri-state data pad is presented as a value and a drive enable, and the pad logic combines them.

Top module: `cfg_rom_serial`

## Requirements
- R1: With `RST_HIGH`=1, a high level on `rst_oe_i` is reset and a low level is output enable. With `RST_HIGH`=0, a low level is reset and a high level is output enable.
- R2: While chip enable (`ce_ni` low) and output enable are both active, each rising clock edge moves the counter on by one. `data_o` shows bit k of the store after k such edges, counting from reset.
- R3: While reset is active, the counter is held at zero and `data_oe_o` is low. After release, the stream starts again from bit 0.
- R4: `data_oe_o` is low whenever chip enable or output enable is inactive.
- R5: While `ce_ni` is high, the counter holds its value. Output resumes at the same bit when `ce_ni` goes low again.
- R6: `ceo_no` is low only when both enables are active and all `DEPTH` bits have been read, that is after `DEPTH` counting edges. Before that it is high.
- R7: After the device has been read, `ceo_no` follows `ce_ni` for as long as output enable stays active.
- R8: When output enable is inactive, `ceo_no` is high. It stays high until the device has been read again from bit 0.
- R9: Past the terminal count the counter saturates at `DEPTH` and never wraps. `data_oe_o` stays low there, so in a chain at most one device drives data in any cycle.
- R10: With `USE_INIT`=1, bit i is `INIT_BITS[i]`. With `USE_INIT`=0, bit i is the XOR of all bits of (i XOR (i >> 1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock; rising edge advances the counter |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| ce_ni | input | 1 | Chip enable, active low |
| rst_oe_i | input | 1 | Combined reset / output enable, polarity set by `RST_HIGH` |
| data_o | output | 1 | Current stored bit (0 when not driven) |
| data_oe_o | output | 1 | Drive enable for the data pad |
| ceo_no | output | 1 | Cascade enable to the next device, active low |

## Verification
The checker watches the counter rules on every cycle: the clear under reset, the single step while enabled, the hold while chip enable is inactive, and saturation at the terminal count. It also checks on every cycle that the data pad and the cascade enable never both claim the chain, and that cascade enable stays high before the terminal count and whenever output enable is inactive. Only the bench scenarios can show that the bits arrive in stored order across a two-device chain. They also show a seamless handover at the terminal count, a restart from bit 0 after a reset in the middle of the stream, resumption at the right bit after a freeze, the two reset polarities, and both sources of contents.

// File: rtl/cfg_rom_pkg.sv
`timescale 1ns/1ps
package cfg_rom_pkg;

  typedef struct packed {
    logic en;   // both enables active: count and drive
    logic clr;  // reset level on the shared pin
  } rom_ctrl_t;

  // fallback contents: parity of the Gray code of the bit index
  function automatic logic gray_parity(input int unsigned idx);
    int unsigned g;
    g = idx ^ (idx >> 1);
    return ^g;
  endfunction

endpackage

// File: rtl/cfg_rom_ctrl.sv
`timescale 1ns/1ps
module cfg_rom_ctrl #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic                  ce_ni,
  input  logic                  rst_oe_i,
  output cfg_rom_pkg::rom_ctrl_t ctrl_o
);
  logic rst_lvl;

  generate
    if (RST_HIGH) begin : g_rst_high
      assign rst_lvl = rst_oe_i;
    end else begin : g_rst_low
      assign rst_lvl = ~rst_oe_i;
    end
  endgenerate

  assign ctrl_o.clr = rst_lvl;
  assign ctrl_o.en  = ~ce_ni & ~rst_lvl;
endmodule

// File: rtl/cfg_rom_addr_cnt.sv
`timescale 1ns/1ps
module cfg_rom_addr_cnt #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o
);
  localparam logic [AW-1:0] TC_PAST = AW'(DEPTH);

  logic [AW-1:0] cnt_q;

  assign done_o = (cnt_q == TC_PAST);
  assign addr_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (adv_i && !done_o) begin
      cnt_q <= cnt_q + AW'(1);  // saturates one past the last bit
    end
  end
endmodule

// File: rtl/cfg_rom_store.sv
`timescale 1ns/1ps
module cfg_rom_store #(
  parameter int               DEPTH     = 64,
  parameter bit               USE_INIT  = 1'b0,
  parameter logic [DEPTH-1:0] INIT_BITS = '0,
  localparam int AW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [AW-1:0] addr_i,
  output logic          bit_o
);
  logic [DEPTH-1:0] bits;
  logic [IW-1:0]    sel;

  generate
    if (USE_INIT) begin : g_param
      assign bits = INIT_BITS;
    end else begin : g_dflt
      for (genvar g = 0; g < DEPTH; g++) begin : g_bit
        assign bits[g] = cfg_rom_pkg::gray_parity(g);
      end
    end
  endgenerate

  assign sel   = addr_i[IW-1:0];
  assign bit_o = (int'(addr_i) < DEPTH) ? bits[sel] : 1'b0;
endmodule

// File: rtl/cfg_rom_serial.sv
`timescale 1ns/1ps
module cfg_rom_serial #(
  parameter int               DEPTH     = 64,
  parameter bit               RST_HIGH  = 1'b1,
  parameter bit               USE_INIT  = 1'b0,
  parameter logic [DEPTH-1:0] INIT_BITS = '0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic rst_oe_i,
  output logic data_o,
  output logic data_oe_o,
  output logic ceo_no
);
  localparam int AW = $clog2(DEPTH + 1);

  cfg_rom_pkg::rom_ctrl_t ctrl;
  logic [AW-1:0]          cnt_addr;
  logic                   cnt_done;
  logic                   rd_bit;

  cfg_rom_ctrl #(.RST_HIGH(RST_HIGH)) u_ctrl (
    .ce_ni    (ce_ni),
    .rst_oe_i (rst_oe_i),
    .ctrl_o   (ctrl)
  );

  cfg_rom_addr_cnt #(.DEPTH(DEPTH)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ctrl.clr),
    .adv_i  (ctrl.en),
    .addr_o (cnt_addr),
    .done_o (cnt_done)
  );

  cfg_rom_store #(
    .DEPTH     (DEPTH),
    .USE_INIT  (USE_INIT),
    .INIT_BITS (INIT_BITS)
  ) u_store (
    .addr_i (cnt_addr),
    .bit_o  (rd_bit)
  );

  // release the line once read so the next device in the chain can drive it
  assign data_oe_o = ctrl.en & ~cnt_done;
  assign data_o    = data_oe_o & rd_bit;
  assign ceo_no    = ~(ctrl.en & cnt_done);
endmodule

// File: rtl/cfg_rom_serial_chk.sv
`timescale 1ns/1ps
module cfg_rom_serial_chk #(
  parameter int DEPTH    = 64,
  parameter bit RST_HIGH = 1'b1
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         ce_ni,
  input logic                         rst_oe_i,
  input logic                         data_oe_o,
  input logic                         ceo_no,
  input logic [$clog2(DEPTH+1)-1:0]   addr_i
);
  logic rst_lvl;
  logic en;

  assign rst_lvl = RST_HIGH ? rst_oe_i : !rst_oe_i;
  assign en      = !ce_ni && !rst_lvl;

  // R3
  rst_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_lvl |=> (addr_i == '0));

  // R2
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && int'(addr_i) < DEPTH) |=> (int'(addr_i) == int'($past(addr_i)) + 1));

  // R5
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni && !rst_lvl) |=> $stable(addr_i));

  // R4
  oe_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> !data_oe_o);

  // R9
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(addr_i) <= DEPTH);

  // R9
  one_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ceo_no |-> !data_oe_o);

  // R6
  early_ceo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(addr_i) < DEPTH) |-> ceo_no);

  // R8
  oe_off_ceo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_lvl |-> ceo_no);
endmodule

bind cfg_rom_serial cfg_rom_serial_chk #(
  .DEPTH    (DEPTH),
  .RST_HIGH (RST_HIGH)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ce_ni     (ce_ni),
  .rst_oe_i  (rst_oe_i),
  .data_oe_o (data_oe_o),
  .ceo_no    (ceo_no),
  .addr_i    (cnt_addr)
);

// File: tb/test_cfg_rom_serial.sv
`timescale 1ns/1ps
module test_cfg_rom_serial;
  localparam int          DA     = 16;
  localparam int          DB     = 24;
  localparam int          DC     = 8;
  localparam logic [15:0] A_INIT = 16'hB3C5;

  logic clk = 1'b0;
  logic rst_ni, roe, ce_a, roe_c, ce_c;
  logic d_a, oe_a, ceo_a, d_b, oe_b, ceo_b, d_c, oe_c, ceo_c;
  logic bus;
  logic mon_en = 1'b0;
  int   checks = 0;
  int   errors = 0;
  int   exp_q[$];

  always #4 clk = ~clk;

  // chain: A -> B sharing clock, reset/oe and data; both active-low reset
  cfg_rom_serial #(.DEPTH(DA), .RST_HIGH(1'b0), .USE_INIT(1'b1), .INIT_BITS(A_INIT)) i_cfg_rom_serial (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_a), .rst_oe_i(roe),
    .data_o(d_a), .data_oe_o(oe_a), .ceo_no(ceo_a));

  cfg_rom_serial #(.DEPTH(DB), .RST_HIGH(1'b0), .USE_INIT(1'b0)) i_cfg_rom_serial_b (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ceo_a), .rst_oe_i(roe),
    .data_o(d_b), .data_oe_o(oe_b), .ceo_no(ceo_b));

  // standalone, active-high reset
  cfg_rom_serial #(.DEPTH(DC), .RST_HIGH(1'b1), .USE_INIT(1'b0)) i_cfg_rom_serial_c (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_c), .rst_oe_i(roe_c),
    .data_o(d_c), .data_oe_o(oe_c), .ceo_no(ceo_c));

  assign bus = oe_a ? d_a : (oe_b ? d_b : 1'b0);

  function automatic int dflt(input int i);
    logic [31:0] g;
    g = 32'(i) ^ (32'(i) >> 1);
    return int'(^g);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // driver side of the scoreboard
  task automatic push_chain(input int nb);
    for (int i = 0; i < DA; i++) exp_q.push_back(int'(A_INIT[i]));
    for (int i = 0; i < nb; i++) exp_q.push_back(dflt(i));
  endtask

  task automatic drain();
    for (int n = 0; n < 300 && exp_q.size() != 0; n++) @(posedge clk);
    chk("R2 stream complete", exp_q.size(), 0);
  endtask

  task automatic end_of_chain();
    @(negedge clk);
    chk("R9 A released", int'(oe_a), 0);
    chk("R9 B released", int'(oe_b), 0);
    chk("R6 A ceo low after read", int'(ceo_a), 0);
    chk("R6 B ceo low after read", int'(ceo_b), 0);
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R9 B no wrap", int'(oe_b), 0);
    chk("R9 B ceo held", int'(ceo_b), 0);
  endtask

  // monitor: pop expected bit whenever the shared line is driven
  always @(negedge clk) begin
    if (mon_en && (oe_a || oe_b)) begin
      chk("R9 single driver", int'(oe_a && oe_b), 0);
      if (exp_q.size() == 0) begin
        chk("R2 unexpected bit", 1, 0);
      end else begin
        chk("R2 R10 stream bit", int'(bus), exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; roe = 1'b0; ce_a = 1'b0; roe_c = 1'b1; ce_c = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    @(negedge clk);
    chk("R3 A idle in reset", int'(oe_a), 0);
    chk("R3 B idle in reset", int'(oe_b), 0);
    chk("R8 A ceo high in reset", int'(ceo_a), 1);
    chk("R1 C held by high level", int'(oe_c), 0);
    chk("R8 C ceo high", int'(ceo_c), 1);

    // full chain read
    push_chain(DB);
    mon_en = 1'b1;
    tick(); roe = 1'b1;
    @(negedge clk);
    chk("R6 A ceo high before tc", int'(ceo_a), 1);
    chk("R1 A enabled by high level", int'(oe_a), 1);
    drain();
    end_of_chain();

    // R7: ceo follows ce after read
    tick(); ce_a = 1'b1;
    @(negedge clk);
    chk("R7 ceo follows ce high", int'(ceo_a), 1);
    chk("R4 A off with ce inactive", int'(oe_a), 0);
    chk("R4 B off with chain ce high", int'(oe_b), 0);
    tick(); ce_a = 1'b0;
    @(negedge clk);
    chk("R7 ceo follows ce low", int'(ceo_a), 0);

    // R8: oe inactive forces ceo high until read again
    tick(); roe = 1'b0;
    @(negedge clk);
    chk("R8 ceo high on oe off", int'(ceo_a), 1);
    chk("R3 A released in reset", int'(oe_a), 0);
    repeat (3) tick();
    @(negedge clk);
    chk("R8 ceo stays high", int'(ceo_a), 1);

    // mid-stream reset: A complete plus four bits of B, then reset
    push_chain(4);
    tick(); roe = 1'b1;
    repeat (DA + 4) @(negedge clk);
    #1 mon_en = 1'b0; roe = 1'b0;
    chk("R2 partial stream complete", exp_q.size(), 0);
    @(negedge clk);
    chk("R3 A released mid-stream", int'(oe_a), 0);
    chk("R3 B released mid-stream", int'(oe_b), 0);
    chk("R8 ceo high after mid reset", int'(ceo_a), 1);
    exp_q.delete();
    push_chain(DB);
    mon_en = 1'b1;
    tick(); roe = 1'b1;
    drain();  // R3 both restart from bit 0
    end_of_chain();

    // R5: freeze A mid-stream, expect contiguous bits afterwards
    tick(); roe = 1'b0;
    tick();
    push_chain(DB);
    roe = 1'b1;
    repeat (5) @(posedge clk);
    #1 ce_a = 1'b1;
    @(negedge clk);
    chk("R5 A off while frozen", int'(oe_a), 0);
    repeat (3) tick();
    ce_a = 1'b0;
    drain();
    end_of_chain();
    mon_en = 1'b0;

    // R1 / R10: active-high instance with computed contents
    tick(); roe_c = 1'b0;
    for (int i = 0; i < DC; i++) begin
      @(negedge clk);
      chk("R10 C default bit", int'(d_c), dflt(i));
      chk("R1 C drives on low level", int'(oe_c), 1);
    end
    @(negedge clk);
    chk("R9 C released past tc", int'(oe_c), 0);
    chk("R6 C ceo low after read", int'(ceo_c), 0);
    tick(); roe_c = 1'b1;
    @(negedge clk);
    chk("R1 C reset by high level", int'(ceo_c), 1);
    chk("R3 C released", int'(oe_c), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule